// File: doc/BRIEF.md
# Timer Counter with Coherent Byte Read

This block is a free-running up-counter that advances once for every cycle in which a prescaled tick input is high. The full count is driven out on a wide port so compare logic next to it can use it. A processor on a narrow data bus reads the same count as two bytes through a small register read port.

Reading two halves of a moving counter one after the other can tear: a carry from the low half into the high half between the two reads gives a value the counter never held. To prevent this, a read of the high-byte offset also copies the live low byte into a holding register. A low-byte read in the very next cycle returns that held copy, so a high-then-low read pair always returns the count as it stood in the high-byte read cycle. Processor writes to the counter offsets are ignored.

When the counter rolls over from all ones to zero it raises a sticky overflow flag. The processor reads the flag at a control offset and clears it by writing a one to its clear bit.

Top module: `tcs_timer_counter`

## Requirements
- R1: During and after a synchronous active-high reset, the count is 0x0000, the overflow flag is 0, and reads of the high and low byte offsets return 0x00 until the counter advances.
- R2: The count increases by exactly one at each clock edge where tick is high, and holds its value at every edge where tick is low.
- R3: With the count at 0xFFFF, a tick makes the next count 0x0000.
- R4: The tick that rolls the count from 0xFFFF to 0x0000 sets the overflow flag, and the flag then stays set through further ticks until it is cleared.
- R5: A write to offset 0x10 with data bit 0 set clears the overflow flag at the next edge. A write there with bit 0 at zero leaves the flag unchanged. A rollover in the same cycle as a clear leaves the flag set.
- R6: A read of offset 0x0E returns bits 15:8 of the current count in the same cycle as the read strobe.
- R7: A read of offset 0x0E stores bits 7:0 of the count in that cycle. A read of offset 0x0F in the immediately following cycle returns that stored byte, even if the counter has advanced or carried into the high byte since then.
- R8: A read of offset 0x0F in any cycle that does not directly follow a read of offset 0x0E returns bits 7:0 of the current count. This includes a second low-byte read in a row, and a low-byte read after a gap cycle.
- R9: Writes to offsets 0x0E and 0x0F have no effect on the count.
- R10: A read of offset 0x10 returns the overflow flag in bit 0 with the upper bits zero. A read of any offset other than 0x0E, 0x0F and 0x10 returns 0x00.
- R11: The read data output is 0x00 in every cycle where the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled count enable, one cycle per count step |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (6) | Register offset |
| wr_data | input | BUS_W (8) | Write data byte |
| rd_data | output | BUS_W (8) | Read data byte, valid in the strobe cycle |
| count | output | 2*BUS_W (16) | Live counter value for compare logic |
| ovf | output | 1 | Sticky rollover flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 16-bit counter and a 6-bit offset. With a 16-bit counter, a full rollover takes about 65,536 ticks, so the bench can drive the count through 0xFFFF and test the overflow flag and its clear. The bench also lines up a high-byte read on a count ending in 0xFF with a tick, so that the carry into the high byte lands between the two reads. It then checks that the snapshot stays coherent across that carry, and that gap cycles and repeated low reads fall back to the live value.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Default geometry and register offsets
    localparam int unsigned DEF_BUS_W   = 8;
    localparam int unsigned DEF_ADDR_W  = 6;
    localparam int unsigned DEF_HI_OFS  = 'h0E;
    localparam int unsigned DEF_LO_OFS  = 'h0F;
    localparam int unsigned DEF_CTL_OFS = 'h10;
    localparam int unsigned DEF_CLR_BIT = 0;

    // Which register a bus access targets
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_CNT_LO = 2'd2,
        SEL_CTL    = 2'd3
    } tcs_sel_e;

    // Decoded bus access
    typedef struct packed {
        logic     rd;
        logic     wr;
        tcs_sel_e sel;
    } tcs_req_t;

    // Map a zero-extended offset onto a register select
    function automatic tcs_sel_e tcs_match(
        input logic [15:0] ofs,
        input logic [15:0] hi_ofs,
        input logic [15:0] lo_ofs,
        input logic [15:0] ctl_ofs
    );
        tcs_sel_e s;
        if (ofs == hi_ofs)       s = SEL_CNT_HI;
        else if (ofs == lo_ofs)  s = SEL_CNT_LO;
        else if (ofs == ctl_ofs) s = SEL_CTL;
        else                     s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/tcs_decode.sv
module tcs_decode
    import tcs_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned HI_OFS  = DEF_HI_OFS,
    parameter int unsigned LO_OFS  = DEF_LO_OFS,
    parameter int unsigned CTL_OFS = DEF_CTL_OFS
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output tcs_req_t          req
);

    localparam logic [15:0] HI_W  = 16'(HI_OFS);
    localparam logic [15:0] LO_W  = 16'(LO_OFS);
    localparam logic [15:0] CTL_W = 16'(CTL_OFS);

    always_comb begin
        req.rd  = rd_en;
        req.wr  = wr_en;
        req.sel = tcs_match(16'(addr), HI_W, LO_W, CTL_W);
    end

endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= count + CNT_ONE;
    end

    assign wrap = tick && (count == CNT_MAX);

    // R2: one step per tick
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + CNT_ONE);

    // R2: no tick, no movement
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R3: rollover lands on zero
    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == '0);

endmodule

// File: rtl/tcs_ovf.sv
module tcs_ovf (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R4: rollover raises the flag
    assert_set_R4: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R4: flag is sticky until cleared
    assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R5: clear drops the flag when no rollover competes
    assert_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/tcs_rdport.sv
module tcs_rdport
    import tcs_pkg::*;
#(
    parameter int unsigned BUS_W = DEF_BUS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tcs_req_t             req,
    input  logic [2*BUS_W-1:0]   count,
    input  logic                 ovf,
    output logic [BUS_W-1:0]     rd_data
);

    localparam int unsigned CNT_W = 2 * BUS_W;

    logic [BUS_W-1:0] cnt_hi;
    logic [BUS_W-1:0] cnt_lo;
    logic             rd_hi;
    logic             rd_lo;
    logic [BUS_W-1:0] snap_q;
    logic             snap_vld_q;

    assign cnt_hi = count[CNT_W-1:BUS_W];
    assign cnt_lo = count[BUS_W-1:0];
    assign rd_hi  = req.rd && (req.sel == SEL_CNT_HI);
    assign rd_lo  = req.rd && (req.sel == SEL_CNT_LO);

    // Low-byte holding register, armed for one cycle by a high-byte read
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else begin
            snap_vld_q <= rd_hi;
            if (rd_hi) snap_q <= cnt_lo;
        end
    end

    always_comb begin
        rd_data = '0;
        if (req.rd) begin
            unique case (req.sel)
                SEL_CNT_HI: rd_data = cnt_hi;
                SEL_CNT_LO: rd_data = snap_vld_q ? snap_q : cnt_lo;
                SEL_CTL:    rd_data = BUS_W'(ovf);
                default:    rd_data = '0;
            endcase
        end
    end

    // R7: low read right after a high read returns the held byte
    assert_snap_R7: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> (!rd_lo || rd_data == $past(cnt_lo)));

    // R8: low read without a preceding high read is live
    assert_live_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !$past(rd_hi)) |-> rd_data == cnt_lo);

endmodule

// File: rtl/tcs_timer_counter.sv
module tcs_timer_counter
    import tcs_pkg::*;
#(
    parameter int unsigned BUS_W   = DEF_BUS_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned HI_OFS  = DEF_HI_OFS,
    parameter int unsigned LO_OFS  = DEF_LO_OFS,
    parameter int unsigned CTL_OFS = DEF_CTL_OFS,
    parameter int unsigned CLR_BIT = DEF_CLR_BIT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [BUS_W-1:0]     rd_data,
    output logic [2*BUS_W-1:0]   count,
    output logic                 ovf
);

    localparam int unsigned CNT_W = 2 * BUS_W;
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(HI_OFS);
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(LO_OFS);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);

    tcs_req_t req;
    logic     wrap;
    logic     ovf_clr;
    logic     unused_wr_bits;

    tcs_decode #(
        .ADDR_W  (ADDR_W),
        .HI_OFS  (HI_OFS),
        .LO_OFS  (LO_OFS),
        .CTL_OFS (CTL_OFS)
    ) u_decode (
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .req   (req)
    );

    tcs_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    // Only the control offset accepts writes; counter offsets drop them
    assign ovf_clr        = req.wr && (req.sel == SEL_CTL) && wr_data[CLR_BIT];
    assign unused_wr_bits = ^wr_data;

    tcs_ovf u_ovf (
        .clk  (clk),
        .rst  (rst),
        .set  (wrap),
        .clr  (ovf_clr),
        .flag (ovf)
    );

    tcs_rdport #(
        .BUS_W (BUS_W)
    ) u_rdport (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .count   (count),
        .ovf     (ovf),
        .rd_data (rd_data)
    );

    // R6: high-byte read shows the live upper half
    assert_hi_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == HI_A) |-> rd_data == count[CNT_W-1:BUS_W]);

    // R9: counter offsets ignore writes
    assert_wr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == HI_A || addr == LO_A) && !tick) |=> $stable(count));

    // R10: control offset reports the flag in bit 0
    assert_ctl_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CTL_A) |-> rd_data == BUS_W'(ovf));

    // R11: quiet bus when not reading
    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);

endmodule

// File: tb/tcs_timer_counter_tb.sv
module tcs_timer_counter_tb;

    localparam logic [5:0] A_HI  = 6'h0E;
    localparam logic [5:0] A_LO  = 6'h0F;
    localparam logic [5:0] A_CTL = 6'h10;
    localparam logic [5:0] A_OTH = 6'h05;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] count;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the architectural state
    logic [15:0] m_cnt = '0;
    logic        m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    tcs_timer_counter u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .count   (count),
        .ovf     (ovf)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: update the model for the edge just passed, then apply new inputs
    task automatic drive(input logic t, input logic r, input logic w,
                         input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        if (rst) begin
            m_cnt = '0;
            m_ovf = 1'b0;
        end else begin
            if (wr_en && addr == A_CTL && wr_data[0]) m_ovf = 1'b0;
            if (tick) begin
                if (m_cnt == 16'hFFFF) m_ovf = 1'b1;
                m_cnt = m_cnt + 16'd1;
            end
        end
        tick = t; rd_en = r; wr_en = w; addr = a; wr_data = d;
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(1, 1, 1, A_CTL, 8'h01);
        drive(1, 1, 0, A_HI, 8'h00);
        drive(0, 0, 0, A_HI, 8'h00);
        check("R1 count in reset", count, 16'h0000);
        check("R1 ovf in reset", {15'd0, ovf}, 16'h0000);
        rst = 1'b0;
        drive(0, 1, 0, A_HI, 8'h00);
        check("R1 hi after reset", {8'd0, rd_data}, 16'h0000);
        drive(0, 1, 0, A_LO, 8'h00);
        check("R1 lo after reset", {8'd0, rd_data}, 16'h0000);
    endtask

    task automatic t_count;
        for (int i = 0; i < 24; i++) begin
            drive((i % 3) != 0, 0, 0, A_OTH, 8'h00);
            check("R2 count tracks ticks", count, m_cnt);
        end
    endtask

    task automatic t_live;
        drive(0, 1, 0, A_HI, 8'h00);
        check("R6 hi read", {8'd0, rd_data}, {8'd0, m_cnt[15:8]});
        drive(1, 0, 0, A_OTH, 8'h00);
        drive(0, 1, 0, A_LO, 8'h00);
        check("R8 lo read after gap", {8'd0, rd_data}, {8'd0, m_cnt[7:0]});
    endtask

    task automatic t_carry;
        logic [15:0] snap_full;
        logic [7:0]  got_hi;
        while (m_cnt[7:0] != 8'hFE) drive(1, 0, 0, A_OTH, 8'h00);
        drive(1, 1, 0, A_HI, 8'h00);          // count ends in FF, tick pending
        check("R6 hi read before carry", {8'd0, rd_data}, {8'd0, m_cnt[15:8]});
        got_hi    = rd_data;
        snap_full = m_cnt;
        drive(1, 1, 0, A_LO, 8'h00);          // carry has landed
        check("R7 lo read returns held byte", {8'd0, rd_data}, {8'd0, snap_full[7:0]});
        check("R7 pair is one snapshot", {got_hi, rd_data}, snap_full);
        check("R2 live count moved past carry", count, snap_full + 16'd1);
        drive(1, 1, 0, A_LO, 8'h00);          // second low read in a row
        check("R8 repeated lo read is live", {8'd0, rd_data}, {8'd0, m_cnt[7:0]});
        drive(1, 1, 0, A_HI, 8'h00);
        drive(1, 0, 0, A_OTH, 8'h00);         // gap cycle
        drive(0, 1, 0, A_LO, 8'h00);
        check("R8 lo read after hi plus gap is live", {8'd0, rd_data}, {8'd0, m_cnt[7:0]});
    endtask

    task automatic t_writes;
        drive(0, 0, 1, A_HI, 8'hAA);
        drive(0, 0, 1, A_LO, 8'h55);
        drive(1, 0, 1, A_LO, 8'h00);
        drive(0, 0, 0, A_OTH, 8'h00);
        check("R9 writes ignored", count, m_cnt);
    endtask

    task automatic t_misc_reads;
        drive(0, 1, 0, A_CTL, 8'h00);
        check("R10 ctl read", {8'd0, rd_data}, {15'd0, m_ovf});
        drive(0, 1, 0, A_OTH, 8'h00);
        check("R10 unmapped read", {8'd0, rd_data}, 16'h0000);
        drive(0, 0, 0, A_HI, 8'h00);
        check("R11 no strobe", {8'd0, rd_data}, 16'h0000);
    endtask

    task automatic t_wrap;
        while (m_cnt != 16'hFFFE) drive(1, 0, 0, A_OTH, 8'h00);
        drive(0, 0, 0, A_OTH, 8'h00);
        check("R3 count at max", count, 16'hFFFF);
        check("R4 ovf clear before wrap", {15'd0, ovf}, 16'h0000);
        drive(1, 0, 0, A_OTH, 8'h00);
        drive(0, 1, 0, A_CTL, 8'h00);
        check("R3 rolled to zero", count, 16'h0000);
        check("R4 ovf set on wrap", {15'd0, ovf}, 16'h0001);
        check("R10 ctl shows ovf", {8'd0, rd_data}, 16'h0001);
        for (int i = 0; i < 4; i++) drive(1, 0, 0, A_OTH, 8'h00);
        drive(0, 0, 0, A_OTH, 8'h00);
        check("R4 ovf sticky", {15'd0, ovf}, 16'h0001);
    endtask

    task automatic t_clear;
        drive(0, 0, 1, A_CTL, 8'hFE);
        drive(0, 0, 0, A_OTH, 8'h00);
        check("R5 bit0 zero keeps ovf", {15'd0, ovf}, {15'd0, m_ovf});
        drive(0, 0, 1, A_CTL, 8'h01);
        drive(0, 0, 0, A_OTH, 8'h00);
        check("R5 clear drops ovf", {15'd0, ovf}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_count();
        t_live();
        t_carry();
        t_writes();
        t_misc_reads();
        t_wrap();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule